// File: doc/BRIEF.md
# Main Clock Source Switch and Peripheral Clock Enable Unit

This block is the control side of a chip's clock tree. The real oscillators, the frequency multiplier and the glitch-free mux live elsewhere. Here the clock tree is modelled as select codes and enables. Software programs the block through a small synchronous register bus. It picks one of four main-clock sources: the 12 MHz internal RC oscillator (the reset choice, needing no setup), the system oscillator, the multiplier output, or a low-power oscillator. It also sets an 8-bit system divide ratio, chooses which of 19 peripherals receive clock, and stores the multiplier's feedback and post-divider codes. The multiplier's lock flag enters as an input.

A new source code does not take effect when it is written. It takes effect only after software arms and fires the commit register: a write with bit 0 clear, then a write with bit 0 set. A small state machine tracks this handshake in three states:
- `SW_STEADY`: no switch in progress.
- `SW_ARMED`: a bit-0-clear write to the commit register moves the machine here from `SW_STEADY`.
- `SW_SWITCH`: a bit-0-set write moves the machine here from `SW_ARMED`.

The machine leaves `SW_SWITCH` for `SW_STEADY` once the pending source may be taken. Any source other than the multiplier may be taken at once. The multiplier may be taken only when its lock flag is high. Software polls bit 0 of the commit register, which reads 0 only while the machine sits in `SW_SWITCH`.

The divided system rate is given as a one-cycle tick enable. Each peripheral enable is that tick ANDed with the peripheral's gate bit.

Top module: `clk_ctrl_unit`

Register addresses (bus_addr):
- 0: pending source, bits 1:0 (0 = internal RC, 1 = system oscillator, 2 = multiplier, 3 = low-power oscillator).
- 1: commit register; bit 0 is written to arm and fire, and reads back the done flag.
- 2: divide ratio, bits 7:0.
- 3: gate mask, bits 18:0.
- 4: multiplier control; feedback code in bits 4:0, post-divider code in bits 6:5.
- 5: status, read only; bit 0 = lock flag, bits 2:1 = active source.

## Requirements
- R1: After reset, main_src is 0 (internal RC) and the divide ratio is 1. The gate mask holds only bit 1, so sys_tick_en is high every cycle and periph_clk_en equals 0x2.
- R2: Writing the pending-source register (address 0) alone never changes main_src.
- R3: A write of bit 0 = 0 to address 1, then a write of bit 0 = 1, loads the pending source into main_src one cycle after the clock edge that accepts the second write. The machine passes through SW_ARMED and SW_SWITCH on the way.
- R4: A bit-0-set write to address 1 while in SW_STEADY has no effect, and main_src stays unchanged.
- R5: When the pending source is 2 (multiplier) and pll_lock is low, the machine holds in SW_SWITCH and main_src is kept. Address 1 reads bit 0 = 0 during this wait. After pll_lock rises, the switch completes one edge later and bit 0 reads 1.
- R6: With divide ratio D (1..255), sys_tick_en is high for one cycle in every D cycles.
- R7: A write of 0 to the divide register is stored as 1. It reads back as 1 and gives a tick every cycle.
- R8: periph_clk_en[i] = gate[i] AND sys_tick_en. Gate bit 1 is forced to 1 on every write, and only bits 18:0 of a gate write are kept.
- R9: Address 4 stores the feedback code in bits 4:0 and the post code in bits 6:5. pll_mult = feedback code + 1 (1..32), pll_post = post code, and the register reads back as written.
- R10: Address 5 reads {active source in bits 2:1, pll_lock in bit 0}.
- R11: Read data appears on bus_rdata in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pll_lock | input | 1 | Multiplier lock flag |
| main_src | output | 2 | Active main-clock source code |
| sys_tick_en | output | 1 | Divided system rate enable |
| periph_clk_en | output | 19 | Per-peripheral clock enables |
| pll_mult | output | 6 | Multiplier factor (feedback code + 1) |
| pll_post | output | 2 | Post-divider code |

## Verification
The bench builds the block with its defaults: 19 peripheral gates, an 8-bit divide ratio, a 5-bit feedback code and a 2-bit post code. The 8-bit ratio makes the largest divide of 255 reachable in a 510-cycle tick count. The 5-bit code lets the top multiplier value of 32 be driven directly. With 19 gates, both the forced bit and the discarded upper write bits can be seen at the ports.

// File: rtl/cku_pkg.sv
package cku_pkg;

    typedef enum logic [1:0] {
        SRC_IRC   = 2'd0,
        SRC_XOSC  = 2'd1,
        SRC_PLL   = 2'd2,
        SRC_LPOSC = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        SW_STEADY = 2'd0,
        SW_ARMED  = 2'd1,
        SW_SWITCH = 2'd2
    } sw_state_e;

    localparam int unsigned REG_SRC  = 0;
    localparam int unsigned REG_UPD  = 1;
    localparam int unsigned REG_DIV  = 2;
    localparam int unsigned REG_GATE = 3;
    localparam int unsigned REG_PLL  = 4;
    localparam int unsigned REG_STAT = 5;

endpackage

// File: rtl/cku_switch_fsm.sv
module cku_switch_fsm
    import cku_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd_wr,
    input  logic     upd_bit,
    input  clk_src_e pend_src,
    input  logic     pll_lock,
    output clk_src_e active_src,
    output logic     sw_done
);

    sw_state_e state_q, state_d;
    logic      may_take;

    // the multiplier may only be taken once it reports lock
    assign may_take = (pend_src != SRC_PLL) || pll_lock;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_STEADY: if (upd_wr && !upd_bit) state_d = SW_ARMED;
            SW_ARMED:  if (upd_wr && upd_bit)  state_d = SW_SWITCH;
            SW_SWITCH: if (may_take)           state_d = SW_STEADY;
            default:                           state_d = SW_STEADY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_STEADY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            active_src <= SRC_IRC;
        else if (state_q == SW_SWITCH && may_take)
            active_src <= pend_src;
    end

    assign sw_done = (state_q != SW_SWITCH);

    // R2
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SW_SWITCH) |=> $stable(active_src));

    // R5
    lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_SWITCH && pend_src == SRC_PLL && !pll_lock)
            |=> ($stable(active_src) && !sw_done));

endmodule

// File: rtl/cku_tick_div.sv
module cku_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last_phase;

    assign last_phase = div_val - DIV_W'(1);
    // >= so a shrinking ratio wraps at once instead of running to overflow
    assign tick = (phase_q >= last_phase);

    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + DIV_W'(1);
    end

    // R7
    unit_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val == DIV_W'(1)) |-> tick);

endmodule

// File: rtl/cku_regfile.sv
module cku_regfile
    import cku_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int NUM_PERIPH = 19,
    parameter int ALWAYS_ON  = 1,
    parameter int DIV_W      = 8,
    parameter int FB_W       = 5,
    parameter int POST_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  sw_done,
    input  clk_src_e              active_src,
    input  logic                  pll_lock,
    output clk_src_e              pend_src,
    output logic                  upd_wr,
    output logic                  upd_bit,
    output logic [DIV_W-1:0]      div_val,
    output logic [NUM_PERIPH-1:0] gate,
    output logic [FB_W-1:0]       fb_code,
    output logic [POST_W-1:0]     post_code
);

    localparam logic [NUM_PERIPH-1:0] ON_MASK = NUM_PERIPH'(1) << ALWAYS_ON;

    logic              wr_en, rd_en;
    logic [DIV_W-1:0]  div_in;
    logic [DATA_W-1:0] rd_next;
    logic              unused_wdata;

    assign wr_en   = bus_valid && bus_write;
    assign rd_en   = bus_valid && !bus_write;
    assign upd_wr  = wr_en && (bus_addr == ADDR_W'(REG_UPD));
    assign upd_bit = bus_wdata[0];
    assign div_in  = bus_wdata[DIV_W-1:0];
    assign unused_wdata = &{1'b0, bus_wdata};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_src  <= SRC_IRC;
            div_val   <= DIV_W'(1);
            gate      <= ON_MASK;
            fb_code   <= '0;
            post_code <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_W'(REG_SRC):  pend_src <= clk_src_e'(bus_wdata[1:0]);
                ADDR_W'(REG_DIV):  div_val  <= (div_in == '0) ? DIV_W'(1) : div_in;
                ADDR_W'(REG_GATE): gate     <= bus_wdata[NUM_PERIPH-1:0] | ON_MASK;
                ADDR_W'(REG_PLL): begin
                    fb_code   <= bus_wdata[FB_W-1:0];
                    post_code <= bus_wdata[FB_W +: POST_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_SRC):  rd_next = DATA_W'(pend_src);
            ADDR_W'(REG_UPD):  rd_next = DATA_W'(sw_done);
            ADDR_W'(REG_DIV):  rd_next = DATA_W'(div_val);
            ADDR_W'(REG_GATE): rd_next = DATA_W'(gate);
            ADDR_W'(REG_PLL):  rd_next = DATA_W'({post_code, fb_code});
            ADDR_W'(REG_STAT): rd_next = DATA_W'({active_src, pll_lock});
            default:           rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_next;
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));

    // R7
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (bus_addr == ADDR_W'(REG_DIV)) |=> (div_val != '0));

endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit
    import cku_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int NUM_PERIPH = 19,
    parameter int ALWAYS_ON  = 1,
    parameter int DIV_W      = 8,
    parameter int FB_W       = 5,
    parameter int POST_W     = 2,
    localparam int MULT_W    = FB_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  pll_lock,
    output logic [1:0]            main_src,
    output logic                  sys_tick_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic [MULT_W-1:0]     pll_mult,
    output logic [POST_W-1:0]     pll_post
);

    clk_src_e              pend_src, active_src;
    logic                  upd_wr, upd_bit, sw_done, tick;
    logic [DIV_W-1:0]      div_val;
    logic [NUM_PERIPH-1:0] gate;
    logic [FB_W-1:0]       fb_code;

    cku_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PERIPH(NUM_PERIPH),
        .ALWAYS_ON(ALWAYS_ON), .DIV_W(DIV_W), .FB_W(FB_W), .POST_W(POST_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sw_done(sw_done), .active_src(active_src), .pll_lock(pll_lock),
        .pend_src(pend_src), .upd_wr(upd_wr), .upd_bit(upd_bit),
        .div_val(div_val), .gate(gate), .fb_code(fb_code), .post_code(pll_post)
    );

    cku_switch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .upd_wr(upd_wr), .upd_bit(upd_bit),
        .pend_src(pend_src), .pll_lock(pll_lock),
        .active_src(active_src), .sw_done(sw_done)
    );

    cku_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick)
    );

    assign main_src      = active_src;
    assign sys_tick_en   = tick;
    assign periph_clk_en = gate & {NUM_PERIPH{tick}};
    assign pll_mult      = MULT_W'(fb_code) + MULT_W'(1);

    // R8
    always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_clk_en[ALWAYS_ON] == sys_tick_en);

endmodule

// File: tb/test_clk_ctrl_unit.sv
`timescale 1ns/1ps
module test_clk_ctrl_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_lock = 1'b0;
    logic [1:0]  main_src;
    logic        sys_tick_en;
    logic [18:0] periph_clk_en;
    logic [5:0]  pll_mult;
    logic [1:0]  pll_post;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    clk_ctrl_unit i_clk_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_lock(pll_lock), .main_src(main_src), .sys_tick_en(sys_tick_en),
        .periph_clk_en(periph_clk_en), .pll_mult(pll_mult), .pll_post(pll_post)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_active, m_pend, m_state, m_div, m_phase, m_gate, m_fb, m_post;
    longint m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active <= 0; m_pend <= 0; m_state <= 0; m_div <= 1; m_phase <= 0;
            m_gate <= 2; m_fb <= 0; m_post <= 0; m_rd <= 0;
        end else begin
            bit t, go, uw;
            t  = (m_phase >= m_div - 1);
            go = (m_pend != 2) || pll_lock;
            uw = bus_valid && bus_write && bus_addr == 3'd1;
            m_phase <= t ? 0 : m_phase + 1;
            if (m_state == 0 && uw && !bus_wdata[0]) m_state <= 1;
            else if (m_state == 1 && uw && bus_wdata[0]) m_state <= 2;
            else if (m_state == 2 && go) begin
                m_state <= 0;
                m_active <= m_pend;
            end
            if (bus_valid && !bus_write) begin
                case (bus_addr)
                    3'd0: m_rd <= m_pend;
                    3'd1: m_rd <= (m_state != 2) ? 1 : 0;
                    3'd2: m_rd <= m_div;
                    3'd3: m_rd <= m_gate;
                    3'd4: m_rd <= m_post * 32 + m_fb;
                    3'd5: m_rd <= m_active * 2 + (pll_lock ? 1 : 0);
                    default: m_rd <= 0;
                endcase
            end
            if (bus_valid && bus_write) begin
                case (bus_addr)
                    3'd0: m_pend <= int'(bus_wdata[1:0]);
                    3'd2: m_div <= (bus_wdata[7:0] == 0) ? 1 : int'(bus_wdata[7:0]);
                    3'd3: m_gate <= int'(bus_wdata[18:0]) | 2;
                    3'd4: begin m_fb <= int'(bus_wdata[4:0]); m_post <= int'(bus_wdata[6:5]); end
                    default: ;
                endcase
            end
        end
    end

    // compare model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit t;
            t = (m_phase >= m_div - 1);
            chk("R6 tick model", sys_tick_en, t);
            chk("R8 periph enables model", periph_clk_en, t ? m_gate : 0);
            chk("R3 main_src model", main_src, m_active);
            chk("R9 pll_mult model", pll_mult, m_fb + 1);
            chk("R9 pll_post model", pll_post, m_post);
            chk("R11 rdata model", bus_rdata, m_rd);
        end
    end

    task automatic wr(input int a, input longint d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a[2:0]; bus_wdata = d[31:0];
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input int a, output longint v);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a[2:0];
        @(negedge clk);
        v = bus_rdata;
        bus_valid = 0;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sys_tick_en) c++;
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        longint v;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 main_src", main_src, 0);
        chk("R1 tick", sys_tick_en, 1);
        chk("R1 periph", periph_clk_en, 2);
        rd(2, v); chk("R1 div", v, 1);
        rd(3, v); chk("R1 gate", v, 2);

        // R2 write source alone
        wr(0, 1);
        repeat (4) @(negedge clk);
        chk("R2 src unchanged", main_src, 0);
        rd(0, v); chk("R2 pending readback", v, 1);

        // R4 fire without arming
        wr(1, 1);
        repeat (3) @(negedge clk);
        chk("R4 no effect", main_src, 0);

        // R3 arm then fire
        wr(1, 0);
        wr(1, 1);
        chk("R3 not yet", main_src, 0);
        @(negedge clk);
        chk("R3 applied", main_src, 1);

        // R5 multiplier without lock
        wr(0, 2);
        wr(1, 0);
        wr(1, 1);
        repeat (5) @(negedge clk);
        chk("R5 held", main_src, 1);
        rd(1, v); chk("R5 busy", v, 0);
        pll_lock = 1;
        @(negedge clk);
        chk("R5 switched", main_src, 2);
        rd(1, v); chk("R5 done", v, 1);
        rd(5, v); chk("R10 status", v, 5);
        repeat (3) @(negedge clk);
        chk("R11 hold", bus_rdata, 5);

        // R6 divide ratios
        wr(2, 4);
        count_ticks(40, c); chk("R6 div4", c, 10);
        wr(2, 255);
        count_ticks(510, c); chk("R6 div255", c, 2);
        wr(2, 1);
        count_ticks(20, c); chk("R6 div1", c, 20);

        // R7 zero ratio
        wr(2, 0);
        rd(2, v); chk("R7 readback", v, 1);
        count_ticks(10, c); chk("R7 ticks", c, 10);

        // R8 gate mask
        wr(3, 0);
        rd(3, v); chk("R8 forced bit", v, 2);
        wr(3, 'h7FFFF);
        @(negedge clk);
        chk("R8 all on", periph_clk_en, 'h7FFFF);
        wr(3, 'hFFF80005);
        rd(3, v); chk("R8 upper ignored", v, 7);
        chk("R8 periph", periph_clk_en, 7);
        wr(2, 3);
        count_ticks(9, c); chk("R8 gated by tick", c, 3);

        // R9 multiplier control
        wr(4, 'h43);
        chk("R9 mult", pll_mult, 4);
        chk("R9 post", pll_post, 2);
        rd(4, v); chk("R9 readback", v, 'h43);
        wr(4, 'h7F);
        chk("R9 mult max", pll_mult, 32);
        chk("R9 post max", pll_post, 3);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule